// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Arbiter

This block looks at a set of interrupt sources and, separately for each processor interface, picks the single most urgent source that is eligible for that processor. The winner must pass two strict thresholds: the processor's priority mask and its current running priority. It then drives an IRQ or FIQ request line, depending on the winner's group. Each source carries enable, pending and group bits, an 8-bit priority and a per-processor target mask. Each processor carries its own group enables, an FIQ-routing bit, an acknowledge-control bit, a priority mask and a running priority.

For every processor the block gives the identifier of the highest pending source. It also gives a second identifier filtered for a secure or non-secure reader, which may replace the winner with one of the reserved codes 1022 or 1023. All outputs are registered. The register bus, the acknowledge and end-of-interrupt bookkeeping, and software-generated interrupts sit outside this block.

Top module: `pend_arb`

## Requirements
- R1: A numerically smaller priority wins. Between equal priorities, the source with the smaller identifier wins.
- R2: A source competes for processor c only when it is enabled and pending. In addition, either its identifier is below 32, or bit `k*N_CPU+c` of `src_target` is set (k is the identifier).
- R3: When no source competes, the highest-pending identifier is 1023 and both request lines are low.
- R4: The winner is published as highest pending only if its priority is strictly below the processor's priority mask (`cpu_prio_mask[c*8+:8]`). Otherwise the identifier reads 1023.
- R5: A request line rises only for a published winner whose priority is strictly below the 9-bit running priority (`cpu_run_prio[c*9+:9]`, where 0x100 means idle). The winner's group g must also be enabled in both `dist_grp_en[g]` and `cpu_grp_en[c*2+g]`.
- R6: A group-0 winner drives FIQ when `cpu_fiq_en[c]` is 1. Every other requesting winner drives IRQ. The two lines are never high together.
- R7: If `dist_grp_en` is 00, or both group enables of processor c are 0, then that processor's identifier is 1023 and both of its request lines are low.
- R8: The filtered identifier equals the published one, with two exceptions. A non-secure reader (`cpu_view_sec[c]`=0) sees 1023 for a group-0 winner. A secure reader sees 1022 for a group-1 winner while `cpu_ack_ctl[c]` is 0.
- R9: Outputs change on the clock edge after the inputs change. During reset both identifiers read 1023 and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_enable | input | N_IRQ | Per-source enable |
| src_pending | input | N_IRQ | Per-source pending |
| src_group | input | N_IRQ | Per-source group (0 or 1) |
| src_prio | input | N_IRQ*8 | Source k priority at bits k*8+:8 |
| src_target | input | N_IRQ*N_CPU | Source k, processor c at bit k*N_CPU+c |
| dist_grp_en | input | 2 | Global group enables, bit g for group g |
| cpu_grp_en | input | N_CPU*2 | Per-processor group enables |
| cpu_fiq_en | input | N_CPU | Route group 0 to FIQ |
| cpu_ack_ctl | input | N_CPU | Secure reader may see group-1 winners |
| cpu_prio_mask | input | N_CPU*8 | Per-processor priority mask |
| cpu_run_prio | input | N_CPU*9 | Per-processor running priority |
| cpu_view_sec | input | N_CPU | Reader of the filtered identifier is secure |
| hp_id | output | N_CPU*10 | Highest-pending identifier per processor |
| hp_view_id | output | N_CPU*10 | Security-filtered identifier per processor |
| irq_req | output | N_CPU | IRQ request per processor |
| fiq_req | output | N_CPU | FIQ request per processor |

## Verification
The bench targets priority ties, where a tree that favours the right child would return the larger identifier. It covers priorities equal to the mask or to the running priority, where a non-strict comparison would publish or request too early. It checks untargeted shared sources against targeted-away private ones, which exposes a missing private bypass. It also tests group and security combinations, where a swapped group index or view rule would route to the wrong line or leak a hidden identifier.

// File: rtl/pend_arb_pkg.sv
package pend_arb_pkg;
   localparam int PRIO_W     = 8;
   localparam int ID_W       = 10;
   localparam int PRIV_LIMIT = 32;
   localparam logic [ID_W-1:0]   ID_NONE   = 10'd1023;
   localparam logic [ID_W-1:0]   ID_HIDDEN = 10'd1022;
   localparam logic [PRIO_W:0]   PRIO_IDLE = 9'h100;

   typedef struct packed {
      logic [PRIO_W:0]   pr;
      logic [ID_W-1:0]   id;
      logic              grp;
   } cand_t;
endpackage

// File: rtl/pend_arb_tree.sv
module pend_arb_tree
   import pend_arb_pkg::*;
#(
   parameter int N_IRQ   = 64,
   parameter int N_CPU   = 2,
   parameter int CPU_SEL = 0
) (
   input  logic [N_IRQ-1:0]        en_i,
   input  logic [N_IRQ-1:0]        pend_i,
   input  logic [N_IRQ-1:0]        grp_i,
   input  logic [N_IRQ*PRIO_W-1:0] prio_i,
   input  logic [N_IRQ*N_CPU-1:0]  tgt_i,
   output cand_t                   best_o
);
   localparam int LVL    = $clog2(N_IRQ);
   localparam int LEAVES = 1 << LVL;

   cand_t node [0:2*LEAVES-1];

   genvar k, i;
   generate
      for (k = 0; k < LEAVES; k++) begin : g_leaf
         if (k < N_IRQ) begin : g_real
            localparam bit PRIV = (k < PRIV_LIMIT);
            logic hit;
            assign hit = en_i[k] & pend_i[k] & (PRIV | tgt_i[k*N_CPU+CPU_SEL]);
            assign node[LEAVES+k] = hit ?
               '{pr: {1'b0, prio_i[k*PRIO_W +: PRIO_W]}, id: ID_W'(k), grp: grp_i[k]} :
               '{pr: PRIO_IDLE, id: ID_NONE, grp: 1'b0};
         end else begin : g_pad
            assign node[LEAVES+k] = '{pr: PRIO_IDLE, id: ID_NONE, grp: 1'b0};
         end
      end
      // left subtree always holds the smaller identifiers: right wins only on strictly better priority
      for (i = 1; i < LEAVES; i++) begin : g_node
         assign node[i] = (node[2*i+1].pr < node[2*i].pr) ? node[2*i+1] : node[2*i];
      end
   endgenerate

   assign node[0] = node[1];
   assign best_o  = node[0];
endmodule

// File: rtl/pend_arb_gate.sv
module pend_arb_gate
   import pend_arb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  cand_t             best_i,
   input  logic [1:0]        dist_en_i,
   input  logic [1:0]        cpu_en_i,
   input  logic              fiq_en_i,
   input  logic              ack_ctl_i,
   input  logic [PRIO_W-1:0] mask_i,
   input  logic [PRIO_W:0]   run_i,
   input  logic              sec_i,
   output logic [ID_W-1:0]   hp_o,
   output logic [ID_W-1:0]   view_o,
   output logic              irq_o,
   output logic              fiq_o
);
   logic            any_grp, under_mask, publish, grp_on, req, to_fiq;
   logic [ID_W-1:0] hp_n, view_n;

   always_comb begin
      any_grp    = (|dist_en_i) && (|cpu_en_i);
      under_mask = best_i.pr < {1'b0, mask_i};
      publish    = any_grp && under_mask;
      grp_on     = dist_en_i[best_i.grp] && cpu_en_i[best_i.grp];
      req        = publish && (best_i.pr < run_i) && grp_on;
      to_fiq     = req && !best_i.grp && fiq_en_i;
      hp_n       = publish ? best_i.id : ID_NONE;
      if (!publish)                        view_n = ID_NONE;
      else if (!best_i.grp && !sec_i)      view_n = ID_NONE;
      else if (best_i.grp && sec_i && !ack_ctl_i) view_n = ID_HIDDEN;
      else                                 view_n = best_i.id;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hp_o   <= ID_NONE;
         view_o <= ID_NONE;
         irq_o  <= 1'b0;
         fiq_o  <= 1'b0;
      end else begin
         hp_o   <= hp_n;
         view_o <= view_n;
         irq_o  <= req && !to_fiq;
         fiq_o  <= to_fiq;
      end
   end
endmodule

// File: rtl/pend_arb.sv
module pend_arb
   import pend_arb_pkg::*;
#(
   parameter int N_IRQ = 64,
   parameter int N_CPU = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IRQ-1:0]        src_enable,
   input  logic [N_IRQ-1:0]        src_pending,
   input  logic [N_IRQ-1:0]        src_group,
   input  logic [N_IRQ*8-1:0]      src_prio,
   input  logic [N_IRQ*N_CPU-1:0]  src_target,
   input  logic [1:0]              dist_grp_en,
   input  logic [N_CPU*2-1:0]      cpu_grp_en,
   input  logic [N_CPU-1:0]        cpu_fiq_en,
   input  logic [N_CPU-1:0]        cpu_ack_ctl,
   input  logic [N_CPU*8-1:0]      cpu_prio_mask,
   input  logic [N_CPU*9-1:0]      cpu_run_prio,
   input  logic [N_CPU-1:0]        cpu_view_sec,
   output logic [N_CPU*10-1:0]     hp_id,
   output logic [N_CPU*10-1:0]     hp_view_id,
   output logic [N_CPU-1:0]        irq_req,
   output logic [N_CPU-1:0]        fiq_req
);
   generate
      if ((N_IRQ % 32) != 0 || N_IRQ < 32 || N_IRQ > 1020) begin : g_bad_irq
         $error("pend_arb: N_IRQ must be a multiple of 32 no larger than 1020");
      end
      if (N_CPU < 1 || N_CPU > 8) begin : g_bad_cpu
         $error("pend_arb: N_CPU must lie in 1..8");
      end
   endgenerate

   genvar c;
   generate
      for (c = 0; c < N_CPU; c++) begin : g_cpu
         cand_t best;

         pend_arb_tree #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .CPU_SEL(c)) u_tree (
            .en_i   (src_enable),
            .pend_i (src_pending),
            .grp_i  (src_group),
            .prio_i (src_prio),
            .tgt_i  (src_target),
            .best_o (best)
         );

         pend_arb_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .best_i    (best),
            .dist_en_i (dist_grp_en),
            .cpu_en_i  (cpu_grp_en[c*2 +: 2]),
            .fiq_en_i  (cpu_fiq_en[c]),
            .ack_ctl_i (cpu_ack_ctl[c]),
            .mask_i    (cpu_prio_mask[c*8 +: 8]),
            .run_i     (cpu_run_prio[c*9 +: 9]),
            .sec_i     (cpu_view_sec[c]),
            .hp_o      (hp_id[c*10 +: 10]),
            .view_o    (hp_view_id[c*10 +: 10]),
            .irq_o     (irq_req[c]),
            .fiq_o     (fiq_req[c])
         );
      end
   endgenerate
endmodule

// File: rtl/pend_arb_chk.sv
module pend_arb_chk #(
   parameter int N_IRQ = 64,
   parameter int N_CPU = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_IRQ-1:0]     src_enable,
   input logic [N_IRQ-1:0]     src_pending,
   input logic [1:0]           dist_grp_en,
   input logic [N_CPU*10-1:0]  hp_id,
   input logic [N_CPU*10-1:0]  hp_view_id,
   input logic [N_CPU-1:0]     irq_req,
   input logic [N_CPU-1:0]     fiq_req
);
   // R6
   irq_fiq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req & fiq_req) == '0);

   // R7
   dist_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dist_grp_en == 2'b00) |=> (irq_req == '0 && fiq_req == '0));

   genvar c;
   generate
      for (c = 0; c < N_CPU; c++) begin : g_c
         // R5
         req_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[c] || fiq_req[c]) |-> (hp_id[c*10 +: 10] != 10'd1023));
         // R8
         view_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hp_id[c*10 +: 10] == 10'd1023) |-> (hp_view_id[c*10 +: 10] == 10'd1023));
         // R3
         no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((src_enable & src_pending) == '0) |=> (hp_id[c*10 +: 10] == 10'd1023));
      end
   endgenerate
endmodule

bind pend_arb pend_arb_chk #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_enable  (src_enable),
   .src_pending (src_pending),
   .dist_grp_en (dist_grp_en),
   .hp_id       (hp_id),
   .hp_view_id  (hp_view_id),
   .irq_req     (irq_req),
   .fiq_req     (fiq_req)
);

// File: tb/sim_pend_arb.sv
`timescale 1ns/1ps
module sim_pend_arb;
   localparam int NI = 64;
   localparam int NC = 2;
   localparam int NROWS = 11;

   logic                clk = 1'b0;
   logic                rst_n;
   logic [NI-1:0]       src_enable, src_pending, src_group;
   logic [NI*8-1:0]     src_prio;
   logic [NI*NC-1:0]    src_target;
   logic [1:0]          dist_grp_en;
   logic [NC*2-1:0]     cpu_grp_en;
   logic [NC-1:0]       cpu_fiq_en, cpu_ack_ctl, cpu_view_sec;
   logic [NC*8-1:0]     cpu_prio_mask;
   logic [NC*9-1:0]     cpu_run_prio;
   logic [NC*10-1:0]    hp_id, hp_view_id;
   logic [NC-1:0]       irq_req, fiq_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   pend_arb #(.N_IRQ(NI), .N_CPU(NC)) u0 (
      .clk(clk), .rst_n(rst_n), .src_enable(src_enable), .src_pending(src_pending),
      .src_group(src_group), .src_prio(src_prio), .src_target(src_target),
      .dist_grp_en(dist_grp_en), .cpu_grp_en(cpu_grp_en), .cpu_fiq_en(cpu_fiq_en),
      .cpu_ack_ctl(cpu_ack_ctl), .cpu_prio_mask(cpu_prio_mask), .cpu_run_prio(cpu_run_prio),
      .cpu_view_sec(cpu_view_sec), .hp_id(hp_id), .hp_view_id(hp_view_id),
      .irq_req(irq_req), .fiq_req(fiq_req)
   );

   typedef struct packed {
      logic [7:0] a_id; logic [7:0] a_pr; logic a_g;
      logic [7:0] b_id; logic [7:0] b_pr; logic b_g; logic b_t0;
      logic [7:0] mask; logic [8:0] run;
      logic fiq; logic sec; logic ack;
      logic [9:0] e_hp; logic [9:0] e_view; logic e_irq; logic e_fiq;
   } row_t;

   // Source a targets both CPUs; source b targets CPU1 and CPU0 only when b_t0.
   localparam row_t ROWS [0:NROWS-1] = '{
      '{8'd40, 8'h20, 1'b1, 8'd50, 8'h10, 1'b1, 1'b1, 8'hFF, 9'h100, 1'b0, 1'b0, 1'b0, 10'd50,   10'd50,   1'b1, 1'b0}, // R1 priority
      '{8'd45, 8'h30, 1'b0, 8'd41, 8'h30, 1'b0, 1'b1, 8'hFF, 9'h100, 1'b1, 1'b1, 1'b0, 10'd41,   10'd41,   1'b0, 1'b1}, // R1 tie, R6 fiq
      '{8'd45, 8'h30, 1'b0, 8'd41, 8'h30, 1'b0, 1'b1, 8'hFF, 9'h100, 1'b0, 1'b1, 1'b0, 10'd41,   10'd41,   1'b1, 1'b0}, // R6 irq
      '{8'd40, 8'h20, 1'b1, 8'd35, 8'h05, 1'b1, 1'b0, 8'hFF, 9'h100, 1'b0, 1'b0, 1'b0, 10'd40,   10'd40,   1'b1, 1'b0}, // R2 untargeted
      '{8'd40, 8'h20, 1'b1, 8'd20, 8'h05, 1'b1, 1'b0, 8'hFF, 9'h100, 1'b0, 1'b0, 1'b0, 10'd20,   10'd20,   1'b1, 1'b0}, // R2 private
      '{8'd40, 8'h40, 1'b1, 8'd45, 8'h50, 1'b1, 1'b1, 8'h40, 9'h100, 1'b0, 1'b0, 1'b0, 10'd1023, 10'd1023, 1'b0, 1'b0}, // R4 equal mask
      '{8'd40, 8'h40, 1'b1, 8'd45, 8'h50, 1'b1, 1'b1, 8'h41, 9'h040, 1'b0, 1'b0, 1'b0, 10'd40,   10'd40,   1'b0, 1'b0}, // R5 equal run
      '{8'd40, 8'h40, 1'b1, 8'd45, 8'h50, 1'b1, 1'b1, 8'h41, 9'h041, 1'b0, 1'b0, 1'b0, 10'd40,   10'd40,   1'b1, 1'b0}, // R5 below run
      '{8'd40, 8'h20, 1'b0, 8'd45, 8'h30, 1'b1, 1'b1, 8'hFF, 9'h100, 1'b1, 1'b0, 1'b0, 10'd40,   10'd1023, 1'b0, 1'b1}, // R8 ns g0
      '{8'd40, 8'h20, 1'b1, 8'd45, 8'h30, 1'b0, 1'b1, 8'hFF, 9'h100, 1'b0, 1'b1, 1'b0, 10'd40,   10'd1022, 1'b1, 1'b0}, // R8 s g1 ack0
      '{8'd40, 8'h20, 1'b1, 8'd45, 8'h30, 1'b0, 1'b1, 8'hFF, 9'h100, 1'b0, 1'b1, 1'b1, 10'd40,   10'd40,   1'b1, 1'b0}  // R8 s g1 ack1
   };

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_src();
      src_enable = '0; src_pending = '0; src_group = '0;
      src_prio = '0; src_target = '0;
   endtask

   task automatic add_src(int id, int pr, bit g, bit t0, bit t1);
      src_enable[id] = 1'b1; src_pending[id] = 1'b1; src_group[id] = g;
      src_prio[id*8 +: 8] = pr[7:0];
      src_target[id*NC+0] = t0; src_target[id*NC+1] = t1;
   endtask

   task automatic defaults();
      dist_grp_en = 2'b11; cpu_grp_en = 4'b0011;
      cpu_fiq_en = '0; cpu_ack_ctl = '0; cpu_view_sec = '0;
      cpu_prio_mask = {8'hFF, 8'hFF}; cpu_run_prio = {9'h100, 9'h100};
   endtask

   task automatic settle();
      @(posedge clk); #1;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      rst_n = 1'b0;
      clear_src();
      defaults();
      repeat (2) @(posedge clk);
      #1;
      // R9 reset state
      check("R9 reset hp", int'(hp_id[9:0]), 1023);
      check("R9 reset view", int'(hp_view_id[9:0]), 1023);
      check("R9 reset req", int'({irq_req, fiq_req}), 0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         defaults(); clear_src();
         add_src(ROWS[i].a_id, ROWS[i].a_pr, ROWS[i].a_g, 1'b1, 1'b1);
         add_src(ROWS[i].b_id, ROWS[i].b_pr, ROWS[i].b_g, ROWS[i].b_t0, 1'b1);
         cpu_prio_mask[7:0] = ROWS[i].mask;
         cpu_run_prio[8:0]  = ROWS[i].run;
         cpu_fiq_en[0] = ROWS[i].fiq; cpu_view_sec[0] = ROWS[i].sec; cpu_ack_ctl[0] = ROWS[i].ack;
         settle();
         check($sformatf("R1 R2 R4 R5 R6 R8 row%0d hp", i), int'(hp_id[9:0]), int'(ROWS[i].e_hp));
         check($sformatf("R8 row%0d view", i), int'(hp_view_id[9:0]), int'(ROWS[i].e_view));
         check($sformatf("R5 R6 row%0d irq", i), int'(irq_req[0]), int'(ROWS[i].e_irq));
         check($sformatf("R6 row%0d fiq", i), int'(fiq_req[0]), int'(ROWS[i].e_fiq));
      end

      // R3 nothing competing
      @(negedge clk); defaults(); clear_src(); settle();
      check("R3 empty hp", int'(hp_id[9:0]), 1023);
      check("R3 empty req", int'({irq_req[0], fiq_req[0]}), 0);
      // R3 pending but disabled, enabled but not pending
      @(negedge clk); src_pending[40] = 1'b1; src_target = '1; src_enable[41] = 1'b1; settle();
      check("R3 not enabled or not pending", int'(hp_id[9:0]), 1023);

      // R9 one-cycle latency
      @(negedge clk); clear_src(); add_src(40, 8'h20, 1'b1, 1'b1, 1'b1);
      #2;
      check("R9 before edge", int'(hp_id[9:0]), 1023);
      settle();
      check("R9 after edge", int'(hp_id[9:0]), 40);

      // R1 ties across subtrees and extremes
      @(negedge clk); clear_src(); add_src(63, 8'h77, 1'b1, 1'b1, 1'b1); add_src(32, 8'h77, 1'b1, 1'b1, 1'b1); settle();
      check("R1 tie lowest id", int'(hp_id[9:0]), 32);
      @(negedge clk); clear_src(); add_src(62, 8'hFF, 1'b1, 1'b1, 1'b1); add_src(33, 8'h00, 1'b1, 1'b1, 1'b1); settle();
      check("R1 priority zero", int'(hp_id[9:0]), 33);
      // R4 priority 0xFF never under mask 0xFF
      @(negedge clk); clear_src(); add_src(50, 8'hFF, 1'b1, 1'b1, 1'b1); settle();
      check("R4 ff vs mask ff", int'(hp_id[9:0]), 1023);

      // R2 per-processor targeting
      @(negedge clk); defaults(); cpu_grp_en = 4'b1111; clear_src(); add_src(60, 8'h10, 1'b1, 1'b0, 1'b1); settle();
      check("R2 cpu0 untargeted", int'(hp_id[9:0]), 1023);
      check("R2 cpu1 hp", int'(hp_id[19:10]), 60);
      check("R2 cpu1 irq", int'(irq_req[1]), 1);

      // R5 group enable at each level
      @(negedge clk); defaults(); clear_src(); add_src(40, 8'h20, 1'b1, 1'b1, 1'b1); dist_grp_en = 2'b01; settle();
      check("R5 dist g1 off hp", int'(hp_id[9:0]), 40);
      check("R5 dist g1 off irq", int'(irq_req[0]), 0);
      @(negedge clk); dist_grp_en = 2'b11; cpu_grp_en[1:0] = 2'b01; settle();
      check("R5 cpu g1 off irq", int'(irq_req[0]), 0);

      // R7 all groups off
      @(negedge clk); dist_grp_en = 2'b00; cpu_grp_en[1:0] = 2'b11; settle();
      check("R7 dist off hp", int'(hp_id[9:0]), 1023);
      check("R7 dist off req", int'({irq_req[0], fiq_req[0]}), 0);
      @(negedge clk); dist_grp_en = 2'b11; cpu_grp_en[1:0] = 2'b00; settle();
      check("R7 cpu off hp", int'(hp_id[9:0]), 1023);

      summary();
   end
endmodule